// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A small set of mode inputs decides the shape of each frame: how many data bits are sent, whether a parity bit follows and of which kind, whether an extra bit is appended, and how long the stop time lasts. Bit timing comes from an external tick that pulses sixteen times per bit period. A frame is started by a one-cycle write strobe while the block is idle.

The block reads the mode inputs, the data word and the extra-bit value at the cycle the write is accepted. It holds them for the rest of the frame, so the surrounding logic may change them as soon as the write is taken. While a frame is in flight the busy output is high and further writes are dropped. When the stop time ends, a one-cycle done pulse is raised. A frame may then start on the next cycle. The latched format resets to eight data bits, no parity, no extra bit and a short stop.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in flight, `tx_line` is 1, `busy` is 0 and `done` is 0.
- R2: A write accepted while idle starts a frame on the next cycle. The start bit (0) comes first, then the data bits, least significant first. Every start, data, parity and extra bit lasts exactly 16 `tick16` pulses.
- R3: `mode_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that count are not sent.
- R4: With `mode_par_en` = 1, one parity bit follows the data. `mode_par_type` selects it: 00 is odd (the data bits plus the parity bit hold an odd number of ones), 01 is even, 10 is a constant 1 and 11 is a constant 0. Only the data bits that are sent count toward parity. With `mode_par_en` = 0, no parity bit is sent.
- R5: With `mode_xbit_en` = 1, the value of `xbit_in` is sent as one bit after the parity bit, or after the data when parity is off. With `mode_xbit_en` = 0, no extra bit is sent.
- R6: The stop time holds `tx_line` at 1. It lasts 16 ticks when `mode_stop_long` = 0. When `mode_stop_long` = 1 it lasts 24 ticks for 5 data bits and 32 ticks for 6, 7 or 8 data bits.
- R7: `busy` is 1 from the cycle after an accepted write until the stop time ends. `done` pulses for exactly one cycle when the stop time ends, in the same cycle that `busy` first reads 0 again.
- R8: A write strobe while `busy` is 1 is ignored. It neither changes the frame in flight nor starts a further frame.
- R9: The mode inputs, `wr_data` and `xbit_in` are sampled only when a write is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| wr_en | input | 1 | Write strobe that starts a frame when idle |
| wr_data | input | 8 | Data word to send |
| mode_len | input | 2 | Data length code (5 to 8 bits) |
| mode_par_type | input | 2 | Parity kind: odd, even, one, zero |
| mode_par_en | input | 1 | Parity bit enable |
| mode_xbit_en | input | 1 | Extra bit enable |
| mode_stop_long | input | 1 | Long stop time select |
| xbit_in | input | 1 | Value of the extra bit |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at end of stop time |

## Verification
Frames are sent with every length code using words such as 0x55, 0xA3, 0xFF, 0x00 and 0xE0. The last of these, at five bits, tells apart parity taken over the sent bits from parity taken over the whole byte. Each parity kind is tried with words of odd and of even weight, which separates odd from even and shows whether the constant kinds ignore the data. The extra bit is sent as 0 and as 1, with and without parity, to confirm where it sits. Stop lengths of 16, 24 and 32 ticks are told apart by the tick count at the done pulse. Separate frames change the mode inputs in mid-frame or strobe a write while busy, and the line is then watched for any change to that frame or any frame that was not requested.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_XBIT,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] ptype;
    logic       pen;
    logic       xen;
    logic       slong;
  } tx_cfg_t;

  localparam logic [1:0] PT_ODD   = 2'b00;
  localparam logic [1:0] PT_EVEN  = 2'b01;
  localparam logic [1:0] PT_MARK  = 2'b10;
  localparam logic [1:0] PT_SPACE = 2'b11;

  localparam tx_cfg_t CFG_RESET = '{len: 2'b11, ptype: 2'b00, pen: 1'b0,
                                    xen: 1'b0, slong: 1'b0};

endpackage

// File: rtl/uart_tx_cfg_latch.sv
module uart_tx_cfg_latch
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  tx_cfg_t           cfg_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              xbit_in,
  output tx_cfg_t           cfg_q,
  output logic [DATA_W-1:0] data_q,
  output logic              xbit_q,
  output logic              par_q
);

  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] len_mask;
  logic              weight_odd;
  logic              par_next;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      len_mask[i] = (i < (MIN_BITS + int'(cfg_in.len)));
    end
    weight_odd = ^(data_in & len_mask);
    case (cfg_in.ptype)
      PT_ODD:   par_next = ~weight_odd;
      PT_EVEN:  par_next = weight_odd;
      PT_MARK:  par_next = 1'b1;
      default:  par_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      data_q <= '0;
      xbit_q <= 1'b0;
      par_q  <= 1'b0;
    end else if (load) begin
      cfg_q  <= cfg_in;
      data_q <= data_in;
      xbit_q <= xbit_in;
      par_q  <= par_next;
    end
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OVS = 16,
  parameter int TW  = $clog2(2 * OVS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] target,
  output logic          bit_end
);

  logic [TW-1:0] cnt;

  assign bit_end = run && tick && (cnt == target - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (bit_end) cnt <= '0;
      else         cnt <= cnt + TW'(1);
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < target)); // R6

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int TW     = $clog2(2 * OVS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              bit_end,
  input  tx_cfg_t           cfg_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              xbit_q,
  input  logic              par_q,
  output logic              load,
  output logic              run,
  output logic [TW-1:0]     target,
  output logic              tx_line,
  output logic              busy,
  output logic              done
);

  localparam int          IW     = $clog2(DATA_W);
  localparam logic [TW-1:0] T_BIT  = TW'(OVS);
  localparam logic [TW-1:0] T_MID  = TW'(OVS + OVS / 2);
  localparam logic [TW-1:0] T_LONG = TW'(2 * OVS);

  tx_state_e       state;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   last_idx;
  logic [TW-1:0]   stop_t;

  assign load     = wr_en && (state == ST_IDLE);
  assign run      = (state != ST_IDLE);
  assign last_idx = IW'(DATA_W - 4) + IW'(cfg_q.len);

  always_comb begin
    if (!cfg_q.slong)          stop_t = T_BIT;
    else if (cfg_q.len == 2'b00) stop_t = T_MID;
    else                       stop_t = T_LONG;
    target = (state == ST_STOP) ? stop_t : T_BIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      tx_line <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load) begin
            state   <= ST_START;
            tx_line <= 1'b0;
            busy    <= 1'b1;
          end
        end
        ST_START: begin
          if (bit_end) begin
            state   <= ST_DATA;
            idx     <= '0;
            tx_line <= data_q[0];
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            if (idx != last_idx) begin
              idx     <= idx + IW'(1);
              tx_line <= data_q[idx + IW'(1)];
            end else if (cfg_q.pen) begin
              state   <= ST_PAR;
              tx_line <= par_q;
            end else if (cfg_q.xen) begin
              state   <= ST_XBIT;
              tx_line <= xbit_q;
            end else begin
              state   <= ST_STOP;
              tx_line <= 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            if (cfg_q.xen) begin
              state   <= ST_XBIT;
              tx_line <= xbit_q;
            end else begin
              state   <= ST_STOP;
              tx_line <= 1'b1;
            end
          end
        end
        ST_XBIT: begin
          if (bit_end) begin
            state   <= ST_STOP;
            tx_line <= 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          tx_line <= 1'b1;
          busy    <= 1'b0;
        end
      endcase
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_line); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && tx_line)); // R7

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode_len,
  input  logic [1:0]        mode_par_type,
  input  logic              mode_par_en,
  input  logic              mode_xbit_en,
  input  logic              mode_stop_long,
  input  logic              xbit_in,
  output logic              tx_line,
  output logic              busy,
  output logic              done
);

  localparam int TW = $clog2(2 * OVS + 1);

  tx_cfg_t           cfg_in;
  tx_cfg_t           cfg_q;
  logic [DATA_W-1:0] data_q;
  logic              xbit_q;
  logic              par_q;
  logic              load;
  logic              run;
  logic              bit_end;
  logic [TW-1:0]     target;

  assign cfg_in = '{len: mode_len, ptype: mode_par_type, pen: mode_par_en,
                    xen: mode_xbit_en, slong: mode_stop_long};

  uart_tx_cfg_latch #(.DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .cfg_in  (cfg_in),
    .data_in (wr_data),
    .xbit_in (xbit_in),
    .cfg_q   (cfg_q),
    .data_q  (data_q),
    .xbit_q  (xbit_q),
    .par_q   (par_q)
  );

  uart_tx_bit_timer #(.OVS(OVS), .TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (tick16),
    .target  (target),
    .bit_end (bit_end)
  );

  uart_tx_seq #(.DATA_W(DATA_W), .OVS(OVS), .TW(TW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .bit_end (bit_end),
    .cfg_q   (cfg_q),
    .data_q  (data_q),
    .xbit_q  (xbit_q),
    .par_q   (par_q),
    .load    (load),
    .run     (run),
    .target  (target),
    .tx_line (tx_line),
    .busy    (busy),
    .done    (done)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(data_q))); // R9

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy); // R7

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] mode_len = 2'b11;
  logic [1:0] mode_par_type = 2'b00;
  logic       mode_par_en = 1'b0;
  logic       mode_xbit_en = 1'b0;
  logic       mode_stop_long = 1'b0;
  logic       xbit_in = 1'b0;
  logic       tx_line;
  logic       busy;
  logic       done;

  typedef struct {
    logic [15:0] bits;
    int          nb;
    int          ndata;
    int          par_pos;
    int          x_pos;
    int          stop_t;
    string       tg;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .mode_len(mode_len), .mode_par_type(mode_par_type), .mode_par_en(mode_par_en),
    .mode_xbit_en(mode_xbit_en), .mode_stop_long(mode_stop_long), .xbit_in(xbit_in),
    .tx_line(tx_line), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // tick generator: one pulse every 3 clocks, changed shortly after posedge
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #2;
      tick16 = (k % 3 == 2);
      k++;
    end
  end

  // driver: pushes expected frame and strobes the write
  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic [1:0] pt,
                      input logic pe, input logic xe, input logic sl, input logic xb,
                      input string tg, input bit scramble, input bit poke);
    exp_t e;
    int   ones;
    logic p;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    e.ndata = 5 + int'(len);
    e.bits = '0;
    e.bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < e.ndata; i++) begin
      e.bits[1 + i] = d[i];
      if (d[i]) ones++;
    end
    e.nb = 1 + e.ndata;
    e.par_pos = -1;
    e.x_pos = -1;
    if (pe) begin
      case (pt)
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      e.par_pos = e.nb;
      e.bits[e.nb] = p;
      e.nb++;
    end
    if (xe) begin
      e.x_pos = e.nb;
      e.bits[e.nb] = xb;
      e.nb++;
    end
    e.stop_t = !sl ? 16 : (len == 2'b00 ? 24 : 32);
    e.tg = tg;
    q.push_back(e);
    wr_data = d; mode_len = len; mode_par_type = pt; mode_par_en = pe;
    mode_xbit_en = xe; mode_stop_long = sl; xbit_in = xb;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (scramble) begin
      repeat (20) @(negedge clk);
      wr_data = ~d; mode_len = ~len; mode_par_type = ~pt; mode_par_en = ~pe;
      mode_xbit_en = ~xe; mode_stop_long = ~sl; xbit_in = ~xb;
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      wr_data = 8'h3C; mode_len = 2'b00;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  // monitor: pops expected frames and compares them with the line
  initial begin
    exp_t  e;
    int    c;
    int    total;
    int    k;
    bit    fin;
    string t;
    forever begin
      @(negedge clk);
      if (!rst && !tx_line) begin
        if (q.size() == 0) begin
          chk("R8 unexpected frame start", 1, 0);
          while (!tx_line) @(negedge clk);
        end else begin
          e = q.pop_front();
          total = 16 * e.nb + e.stop_t;
          c = 0;
          fin = 0;
          while (!fin) begin
            if (done) begin
              chk({e.tg, " R6 R7 ticks at done"}, c, total);
              chk({e.tg, " R7 busy low with done"}, int'(busy), 0);
              fin = 1;
            end else begin
              if (tick16) begin
                c++;
                if (c <= 16 * e.nb && (c % 16) == 8) begin
                  k = (c - 8) / 16;
                  if (k == 0)              t = " R2 start bit";
                  else if (k == e.par_pos) t = " R4 parity bit";
                  else if (k == e.x_pos)   t = " R5 extra bit";
                  else                     t = " R2 R3 data bit";
                  chk({e.tg, t}, int'(tx_line), int'(e.bits[k]));
                  chk({e.tg, " R7 busy in frame"}, int'(busy), 1);
                end else if (c > 16 * e.nb) begin
                  chk({e.tg, " R6 stop level"}, int'(tx_line), 1);
                end
                if (c > total + 40) begin
                  chk({e.tg, " R6 R7 done missing"}, c, total);
                  fin = 1;
                end
              end
              if (!fin) @(negedge clk);
            end
          end
          @(negedge clk);
          chk({e.tg, " R7 done single cycle"}, int'(done), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 tx idle in reset", int'(tx_line), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 tx idle", int'(tx_line), 1);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 done idle", int'(done), 0);

    // R2 R3: each length, no parity, short stop
    send(8'h55, 2'b11, 2'b00, 0, 0, 0, 0, "R2", 0, 0);
    send(8'hA3, 2'b11, 2'b00, 0, 0, 0, 0, "R2", 0, 0);
    send(8'h3A, 2'b00, 2'b00, 0, 0, 0, 0, "R3", 0, 0);
    send(8'hD6, 2'b01, 2'b00, 0, 0, 0, 0, "R3", 0, 0);
    send(8'h4B, 2'b10, 2'b00, 0, 0, 0, 0, "R3", 0, 0);
    // R4: parity kinds with odd/even weight words
    send(8'h07, 2'b11, 2'b00, 1, 0, 0, 0, "R4", 0, 0);
    send(8'h03, 2'b11, 2'b00, 1, 0, 0, 0, "R4", 0, 0);
    send(8'h07, 2'b11, 2'b01, 1, 0, 0, 0, "R4", 0, 0);
    send(8'h03, 2'b11, 2'b01, 1, 0, 0, 0, "R4", 0, 0);
    send(8'h00, 2'b11, 2'b10, 1, 0, 0, 0, "R4", 0, 0);
    send(8'hFF, 2'b11, 2'b11, 1, 0, 0, 0, "R4", 0, 0);
    send(8'hE0, 2'b00, 2'b00, 1, 0, 0, 0, "R4", 0, 0);
    send(8'hE1, 2'b00, 2'b01, 1, 0, 0, 0, "R4", 0, 0);
    send(8'h7F, 2'b10, 2'b01, 1, 0, 0, 0, "R4", 0, 0);
    // R5: extra bit
    send(8'h96, 2'b11, 2'b00, 0, 1, 0, 1, "R5", 0, 0);
    send(8'h96, 2'b11, 2'b00, 0, 1, 0, 0, "R5", 0, 0);
    send(8'h5A, 2'b01, 2'b01, 1, 1, 0, 1, "R5", 0, 0);
    send(8'h5B, 2'b10, 2'b10, 1, 1, 0, 0, "R5", 0, 0);
    // R6: stop lengths
    send(8'h15, 2'b00, 2'b00, 0, 0, 1, 0, "R6", 0, 0);
    send(8'hC4, 2'b11, 2'b00, 0, 0, 1, 0, "R6", 0, 0);
    send(8'h2D, 2'b01, 2'b00, 1, 1, 1, 1, "R6", 0, 0);
    send(8'h0E, 2'b00, 2'b11, 1, 1, 1, 1, "R6", 0, 0);
    // R9: inputs change mid-frame
    send(8'h69, 2'b10, 2'b00, 1, 0, 0, 1, "R9", 1, 0);
    send(8'h81, 2'b00, 2'b10, 0, 1, 1, 0, "R9", 1, 0);
    // R8: write while busy
    send(8'hB2, 2'b11, 2'b01, 1, 0, 0, 0, "R8", 0, 1);
    while (busy) @(negedge clk);
    repeat (150) @(negedge clk);
    chk("R8 no extra frame busy", int'(busy), 0);
    chk("R8 no extra frame line", int'(tx_line), 1);
    send(8'hF0, 2'b11, 2'b00, 0, 0, 0, 0, "R7", 0, 0);

    while (busy || q.size() != 0) @(negedge clk);
    repeat (100) @(negedge clk);
    chk("R8 scoreboard drained", q.size(), 0);
    chk("R1 idle at end", int'(tx_line), 1);
    finish_run();
  end

endmodule